// File: doc/BRIEF.md
# Clock Divider Transition Sequencer

This block moves a core clock between five divide settings (1, 2, 4, 6 and 8) and keeps a DRAM controller's refresh setup in step with each new clock. A request carries a target divider index. The block reads back the current divider-mode code and the current memory-control word. It then issues an ordered series of single-cycle register writes to those two registers.

The order of the writes depends on the direction of the change. Between them the block inserts a fixed wait for the PLL to relock and, where needed, a wait for the refresh counters to drain. A jump between divide-by-1 and any divide above 2 is never made directly. It is split into two steps, and the first step always lands on divide-by-2.

The refresh count for each divider is fixed at elaboration from a base-frequency parameter. No division is done at run time. The register file, the PLL and the DRAM controller sit outside the block. They are seen only through the write port and the two read-back inputs.

Top module: `clkdiv_seq`

## Requirements
- R1: Divider indices 0..4 mean divide 1, 2, 4, 6, 8. Their 3-bit codes are 000, 001, 011, 010 and 100. A divider-mode write (wr_addr = 0) carries the code in wr_data[2:0], with every higher bit zero.
- R2: A request with an index above 4 is rejected. So is a request made while the read-back divider code is not one of the five legal codes. A rejected request gives err high for one cycle, in the req_ack cycle, with no write and no done.
- R3: A request whose target equals the current divider gives done in the req_ack cycle, with no write and with busy staying low.
- R4: After a divider-mode write, the next write or done comes exactly 17 cycles later, leaving 16 idle cycles. After a memory-control write, the next one comes 2 cycles later, plus any drain wait from R10.
- R5: A change from divide-1 to divide 4/6/8 runs as two steps, and so does a change from divide 4/6/8 to divide-1. The first step goes to divide-2 and the second goes to the target. No extra cycle is spent between the two steps.
- R6: Step 2→1: clear self-refresh, then write the divider, then rewrite the refresh count.
- R7: Step 1→2: rewrite the refresh count, then write the divider, then set self-refresh.
- R8: Step between dividers both ≥2: when the divider grows, rewrite the count and then write the divider. When it shrinks, write the divider and then rewrite the count.
- R9: Memory-control writes (wr_addr = 1) use read-modify-write. Self-refresh enable is bit 16. The refresh count is bits 14:8 and equals floor(BASE_HZ·7.8e-6 / (64·divide)), capped at 127. All other bits equal the read-back word.
- R10: The count rewrite of a 1→2 step, and of a shrinking step between dividers ≥2, is followed by an extra wait when the written bit 16 is 0. The wait is 64·(old count + new count)·(old divide) cycles.
- R11: A req_valid sampled high while busy is low gives req_ack for one cycle. For a real change, busy rises in that same cycle and the first write follows in the next. busy falls in the cycle of the one-cycle done pulse. A req_valid while busy is ignored. After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Change request |
| req_idx | input | 3 | Target divider index |
| req_ack | output | 1 | Request taken (one cycle) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished (one cycle) |
| err | output | 1 | Request rejected (one cycle) |
| div_mode_q | input | 3 | Read-back of the divider-mode code |
| mem_ctl_q | input | DATA_W | Read-back of the memory-control word |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 1 | 0 = divider-mode, 1 = memory-control |
| wr_data | output | DATA_W | Write data |

## Verification
The bench targets the two split routes, 1→6 and 8→1. A design that jumps directly would write a code other than 001 first. It also covers the direction-dependent ordering, where a swapped order shows up as the wrong register address in a given cycle. The drain wait is run with self-refresh both off and on. A wrong drain length or a wrong enable test moves every later write. Rejected and same-target requests, and a request poked in while busy, are also run. A design that does not ignore them would acknowledge them or write registers.

// File: rtl/clkdiv_seq_pkg.sv
package clkdiv_seq_pkg;

  typedef enum logic [1:0] {OP_SRCLR, OP_SRSET, OP_DIV, OP_CNT} op_e;
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_e;

  localparam int NUM_DIV = 5;

  function automatic logic [2:0] idx2code(logic [2:0] i);
    case (i)
      3'd0:    return 3'b000;
      3'd1:    return 3'b001;
      3'd2:    return 3'b011;
      3'd3:    return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  function automatic logic [3:0] idx2div(logic [2:0] i);
    case (i)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      3'd3:    return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

  // bit 3 flags an illegal code, bits 2:0 give the index
  function automatic logic [3:0] code2idx(logic [2:0] c);
    case (c)
      3'b000:  return 4'b0_000;
      3'b001:  return 4'b0_001;
      3'b011:  return 4'b0_010;
      3'b010:  return 4'b0_011;
      3'b100:  return 4'b0_100;
      default: return 4'b1_000;
    endcase
  endfunction

  // hz * 7.8us / (64 * div), saturated to cap
  function automatic int unsigned refresh_cnt(longint unsigned hz, int unsigned dv,
                                              int unsigned cap);
    longint unsigned v;
    v = (hz * 64'd78) / (64'd640_000_000 * 64'(dv));
    return (v > 64'(cap)) ? cap : int'(v);
  endfunction

endpackage

// File: rtl/clkdiv_step_plan.sv
module clkdiv_step_plan
  import clkdiv_seq_pkg::*;
(
  input  logic [2:0] old_idx,
  input  logic [2:0] new_idx,
  output op_e        op_list [4],
  output logic [1:0] n_ops,
  output logic       slow_step
);
  always_comb begin
    op_list   = '{OP_DIV, OP_DIV, OP_DIV, OP_DIV};
    n_ops     = 2'd2;
    slow_step = 1'b0;
    if (old_idx == 3'd1 && new_idx == 3'd0) begin
      op_list[0] = OP_SRCLR;
      op_list[1] = OP_DIV;
      op_list[2] = OP_CNT;
      n_ops      = 2'd3;
    end else if (old_idx == 3'd0 && new_idx == 3'd1) begin
      op_list[0] = OP_CNT;
      op_list[1] = OP_DIV;
      op_list[2] = OP_SRSET;
      n_ops      = 2'd3;
      slow_step  = 1'b1;
    end else if (old_idx < new_idx) begin
      op_list[0] = OP_CNT;
      op_list[1] = OP_DIV;
    end else begin
      op_list[0] = OP_DIV;
      op_list[1] = OP_CNT;
      slow_step  = 1'b1;
    end
  end
endmodule

// File: rtl/clkdiv_wait_timer.sv
module clkdiv_wait_timer #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
  import clkdiv_seq_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter longint unsigned BASE_HZ  = 64'd500_000_000,
  parameter int              PLL_WAIT = 16,
  parameter int              CNT_LSB  = 8,
  parameter int              CNT_W    = 7,
  parameter int              SREF_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_idx,
  output logic              req_ack,
  output logic              busy,
  output logic              done,
  output logic              err,
  input  logic [2:0]        div_mode_q,
  input  logic [DATA_W-1:0] mem_ctl_q,
  output logic              wr_en,
  output logic              wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int DRAIN_W = CNT_W + 11;
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam logic [DATA_W-1:0] CNT_MASK  = DATA_W'(CNT_MAX) << CNT_LSB;
  localparam logic [DATA_W-1:0] SREF_MASK = DATA_W'(1) << SREF_BIT;
  localparam logic [DATA_W-1:0] KEEP_MASK = ~(CNT_MASK | SREF_MASK);

  // per-divider refresh count, fixed at elaboration
  logic [CNT_W-1:0] cnt_tab [8];
  for (genvar g = 0; g < 8; g++) begin : g_cnt
    if (g < NUM_DIV) begin : g_used
      localparam int unsigned CV = refresh_cnt(BASE_HZ, int'(idx2div(3'(g))), CNT_MAX);
      assign cnt_tab[g] = CNT_W'(CV);
    end else begin : g_pad
      assign cnt_tab[g] = '0;
    end
  end

  st_e               st_q;
  logic [2:0]        old_q, new_q, tgt_q;
  logic              two_q;
  logic [1:0]        ptr_q;
  logic              drain_pend_q, sr_wr_q;
  logic [DRAIN_W-1:0] drain_len_q;

  op_e               op_list [4];
  logic [1:0]        n_ops;
  logic              slow_step;

  clkdiv_step_plan u_plan (
    .old_idx  (old_q),
    .new_idx  (new_q),
    .op_list  (op_list),
    .n_ops    (n_ops),
    .slow_step(slow_step)
  );

  logic               tmr_load, tmr_zero;
  logic [DRAIN_W-1:0] tmr_val;

  clkdiv_wait_timer #(.W(DRAIN_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .zero    (tmr_zero)
  );

  logic [3:0] cur_dec;
  logic       cur_bad, split, at_end, drain_go;
  logic [2:0] cur_idx;
  logic [CNT_W:0]     cnt_sum;
  logic [DRAIN_W-1:0] drain_calc;
  logic [DATA_W-1:0]  cnt_word;

  assign cur_dec  = code2idx(div_mode_q);
  assign cur_bad  = cur_dec[3];
  assign cur_idx  = cur_dec[2:0];
  assign split    = (cur_idx == 3'd0 && req_idx > 3'd1) ||
                    (cur_idx > 3'd1 && req_idx == 3'd0);
  assign at_end   = (ptr_q == n_ops);
  assign drain_go = drain_pend_q && !sr_wr_q && (drain_len_q != '0);
  assign cnt_sum  = {1'b0, mem_ctl_q[CNT_LSB +: CNT_W]} + {1'b0, cnt_tab[new_q]};
  assign drain_calc = (DRAIN_W'(cnt_sum) * DRAIN_W'(idx2div(old_q))) << 6;
  assign cnt_word = (mem_ctl_q & ~CNT_MASK) | (DATA_W'(cnt_tab[new_q]) << CNT_LSB);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (st_q == S_ISSUE && !at_end) begin
      tmr_load = 1'b1;
      tmr_val  = (op_list[ptr_q] == OP_DIV) ? DRAIN_W'(PLL_WAIT - 1) : '0;
    end else if (st_q == S_WAIT && tmr_zero && drain_go) begin
      tmr_load = 1'b1;
      tmr_val  = drain_len_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= S_IDLE;
      old_q <= '0; new_q <= '0; tgt_q <= '0; two_q <= 1'b0; ptr_q <= '0;
      drain_pend_q <= 1'b0; sr_wr_q <= 1'b0; drain_len_q <= '0;
      req_ack <= 1'b0; busy <= 1'b0; done <= 1'b0; err <= 1'b0;
      wr_en <= 1'b0; wr_addr <= 1'b0; wr_data <= '0;
    end else begin
      req_ack <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      wr_en   <= 1'b0;
      case (st_q)
        S_IDLE: if (req_valid) begin
          req_ack <= 1'b1;
          if (req_idx > 3'd4 || cur_bad) err <= 1'b1;
          else if (req_idx == cur_idx)   done <= 1'b1;
          else begin
            busy  <= 1'b1;
            st_q  <= S_ISSUE;
            old_q <= cur_idx;
            tgt_q <= req_idx;
            two_q <= split;
            new_q <= split ? 3'd1 : req_idx;
            ptr_q <= '0;
          end
        end
        S_ISSUE: if (at_end) begin
          done <= 1'b1;
          busy <= 1'b0;
          st_q <= S_IDLE;
        end else begin
          wr_en        <= 1'b1;
          st_q         <= S_WAIT;
          drain_pend_q <= 1'b0;
          case (op_list[ptr_q])
            OP_DIV: begin
              wr_addr <= 1'b0;
              wr_data <= DATA_W'(idx2code(new_q));
            end
            OP_CNT: begin
              wr_addr      <= 1'b1;
              wr_data      <= cnt_word;
              drain_pend_q <= slow_step;
              sr_wr_q      <= mem_ctl_q[SREF_BIT];
              drain_len_q  <= drain_calc;
            end
            OP_SRCLR: begin
              wr_addr <= 1'b1;
              wr_data <= mem_ctl_q & ~SREF_MASK;
            end
            default: begin
              wr_addr <= 1'b1;
              wr_data <= mem_ctl_q | SREF_MASK;
            end
          endcase
        end
        S_WAIT: if (tmr_zero) begin
          if (drain_go) drain_pend_q <= 1'b0;
          else begin
            st_q <= S_ISSUE;
            if (ptr_q + 2'd1 == n_ops && two_q) begin
              old_q <= new_q;
              new_q <= tgt_q;
              two_q <= 1'b0;
              ptr_q <= '0;
            end else ptr_q <= ptr_q + 2'd1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  logic [DRAIN_W-1:0] since_div_q;
  logic               wr_code_bad;
  assign wr_code_bad = code2idx(wr_data[2:0])[3];

  always_ff @(posedge clk) begin
    if (rst)                               since_div_q <= DRAIN_W'(PLL_WAIT);
    else if (wr_en && !wr_addr)            since_div_q <= '0;
    else if (since_div_q < DRAIN_W'(PLL_WAIT)) since_div_q <= since_div_q + 1'b1;
  end

  // R4
  pll_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en || done) |-> since_div_q >= DRAIN_W'(PLL_WAIT));

  // R1
  div_code_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr) |-> (!wr_code_bad && wr_data[DATA_W-1:3] == '0));

  // R9
  keep_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr) |-> ((wr_data ^ $past(mem_ctl_q)) & KEEP_MASK) == '0);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !wr_en);

  // R11
  busy_ack_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !req_ack);

  // R2
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (!busy && !done && !wr_en));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: tb/clkdiv_seq_bench.sv
module clkdiv_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam longint unsigned BASE_HZ = 64'd500_000_000;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_idx = '0;
  logic req_ack, busy, done, err, wr_en, wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [2:0]  div_reg;
  logic [31:0] mem_reg;
  logic        ld = 1'b0;
  logic [2:0]  ld_code = '0;
  logic [31:0] ld_mem = '0;

  int checks = 0, errors = 0;
  logic [2:0]  m_code;
  logic [31:0] m_mem;
  logic [37:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  clkdiv_seq #(.DATA_W(DATA_W), .BASE_HZ(BASE_HZ)) u_clkdiv_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_idx(req_idx),
    .req_ack(req_ack), .busy(busy), .done(done), .err(err),
    .div_mode_q(div_reg), .mem_ctl_q(mem_reg),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  // external registers
  always @(posedge clk) begin
    if (ld) begin
      div_reg <= ld_code;
      mem_reg <= ld_mem;
    end else if (wr_en) begin
      if (!wr_addr) div_reg <= wr_data[2:0];
      else          mem_reg <= wr_data;
    end
  end

  function automatic int dec(logic [2:0] c);
    case (c)
      3'b000: return 0;
      3'b001: return 1;
      3'b011: return 2;
      3'b010: return 3;
      3'b100: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic logic [2:0] codeof(int i);
    logic [2:0] t [5] = '{3'b000, 3'b001, 3'b011, 3'b010, 3'b100};
    return t[i];
  endfunction

  function automatic int divof(int i);
    int t [5] = '{1, 2, 4, 6, 8};
    return t[i];
  endfunction

  function automatic int cntof(int i);
    longint unsigned v;
    v = (BASE_HZ * 78) / (64'd10_000_000 * 64 * 64'(divof(i)));
    return (v > 127) ? 127 : int'(v);
  endfunction

  task automatic push(bit a, bit b, bit d, bit e, bit we, bit ad, logic [31:0] dat);
    exp_q.push_back({a, b, d, e, we, ad, dat});
  endtask

  task automatic idle(int n);
    repeat (n) push(0, 1, 0, 0, 0, 0, '0);
  endtask

  task automatic wr_div(int n);
    push(0, 1, 0, 0, 1, 0, {29'b0, codeof(n)});
    idle(16);
    m_code = codeof(n);
  endtask

  task automatic wr_sr(bit set);
    logic [31:0] d;
    d = m_mem;
    d[16] = set;
    push(0, 1, 0, 0, 1, 1, d);
    idle(1);
    m_mem = d;
  endtask

  task automatic wr_cnt(int o, int n, bit slow);
    logic [31:0] d;
    int oldc, gap;
    oldc = int'(m_mem[14:8]);
    d = m_mem;
    d[14:8] = 7'(cntof(n));
    push(0, 1, 0, 0, 1, 1, d);
    gap = 1;
    if (slow && !d[16]) gap += 64 * (oldc + cntof(n)) * divof(o);
    idle(gap);
    m_mem = d;
  endtask

  task automatic step(int o, int n);
    if (o == 1 && n == 0)      begin wr_sr(0); wr_div(n); wr_cnt(o, n, 0); end
    else if (o == 0 && n == 1) begin wr_cnt(o, n, 1); wr_div(n); wr_sr(1); end
    else if (o < n)            begin wr_cnt(o, n, 0); wr_div(n); end
    else                       begin wr_div(n); wr_cnt(o, n, 1); end
  endtask

  task automatic build(int idx);
    int cur;
    cur = dec(m_code);
    if (idx > 4 || cur < 0) push(1, 0, 0, 1, 0, 0, '0);
    else if (idx == cur)    push(1, 0, 1, 0, 0, 0, '0);
    else begin
      push(1, 1, 0, 0, 0, 0, '0);
      if ((cur == 0 && idx > 1) || (cur > 1 && idx == 0)) begin
        step(cur, 1);
        step(1, idx);
      end else step(cur, idx);
      push(0, 0, 1, 0, 0, 0, '0);
    end
    push(0, 0, 0, 0, 0, 0, '0);
  endtask

  task automatic compare(logic [37:0] e, string tag);
    logic [37:0] g;
    bit bad;
    g = {req_ack, busy, done, err, wr_en, wr_addr, wr_data};
    bad = (g[37:33] != e[37:33]) || (e[33] && (g[32:0] != e[32:0]));
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s at %0t: got ack/busy/done/err/we=%b addr=%b data=%h expected %b addr=%b data=%h",
               tag, $time, g[37:33], g[32], g[31:0], e[37:33], e[32], e[31:0]);
    end
  endtask

  task automatic run_req(int idx, string tag, bit poke);
    int k;
    @(negedge clk);
    req_valid = 1'b1;
    req_idx = 3'(idx);
    build(idx);
    k = 0;
    while (exp_q.size() > 0) begin
      @(negedge clk);
      if (k == 0) req_valid = 1'b0;
      compare(exp_q.pop_front(), tag);
      if (poke && k == 1) begin req_valid = 1'b1; req_idx = 3'((idx + 2) % 5); end
      if (poke && k == 2) req_valid = 1'b0;
      k++;
    end
  endtask

  task automatic set_regs(logic [2:0] c, logic [31:0] m);
    @(negedge clk);
    ld = 1'b1; ld_code = c; ld_mem = m;
    m_code = c; m_mem = m;
    @(negedge clk);
    ld = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R11 watchdog: got still running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    set_regs(3'b000, 32'hC3E2_BCA5);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    compare('0, "R11 reset");
    run_req(1, "R7 R10 R4 R9 R1 1to2", 1);
    run_req(0, "R6 R4 R9 2to1", 1);
    run_req(3, "R5 R7 R8 split 1to6", 1);
    run_req(4, "R8 up 6to8", 0);
    run_req(2, "R8 R10 down 8to4 sref on", 0);
    set_regs(m_code, m_mem & ~32'h0001_0000);
    run_req(1, "R8 R10 down 4to2 drain", 1);
    run_req(1, "R3 same target", 0);
    run_req(5, "R2 index 5", 0);
    run_req(7, "R2 index 7", 0);
    run_req(4, "R8 up 2to8", 0);
    run_req(0, "R5 R6 split 8to1", 1);
    set_regs(3'b101, m_mem);
    run_req(2, "R2 bad code 101", 0);
    set_regs(3'b111, m_mem);
    run_req(0, "R2 bad code 111", 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule